// File: doc/BRIEF.md
# Narrowing Integer Divider with Fault Detection

This block divides a double-width dividend, given as a high half and a low half, by a single-width divisor. It returns a single-width quotient and a single-width remainder. One input picks unsigned or two's-complement signed arithmetic. The dividend is twice as wide as the quotient, so the true quotient may not fit. Before any iteration starts, the block compares the dividend magnitude against a bound derived from the divisor. If the quotient would not fit, or if the divisor is zero, the block reports a fault. In that case it writes no truncated result and keeps its previous results.

A caller offers an operation by raising `start` with the operands for one cycle. The block takes the operands only when `busy` is low, so `start` acts as a valid and `!busy` acts as a ready. The block does not hold an offer that it refuses: a `start` seen while `busy` is high is dropped, and the caller must offer the operation again once `busy` falls. The operands are sampled once, in the cycle the offer is taken. After that they may change freely. On the output side there is no back-pressure. `done` marks a one-cycle window in which `fault`, `quotient` and `remainder` are valid. After that window, `quotient` and `remainder` hold until the next successful operation.

A non-faulting operation produces one quotient bit per cycle with a restoring shift-and-subtract step applied to magnitudes. The signs are fixed up when the result is written.

Top module: `narrow_divider`

## Requirements
- R1: Unsigned mode (`signed_mode`=0): when `dividend_hi` < `divisor`, the block returns quotient = floor(D/divisor) and remainder = D mod divisor, where D = {`dividend_hi`,`dividend_lo`}.
- R2: Unsigned mode: when `dividend_hi` >= `divisor` the block raises a fault. For example, 0x1000 divided by 0x10 faults.
- R3: A zero divisor raises a fault in both modes.
- R4: Signed mode (`signed_mode`=1, all operands two's complement): the quotient is truncated toward zero and its sign is the XOR of the operand signs. The remainder takes the sign of the dividend and has a magnitude below that of the divisor. quotient*divisor + remainder equals the dividend.
- R5: Signed mode: a quotient outside -128..127 raises a fault. This includes -32768 divided by -1, and a quotient of +128.
- R6: A non-faulting operation keeps `busy` high for exactly 8 cycles after the accepting edge. `done` then rises for a single cycle, with `fault` low, in the same cycle that `busy` falls. `done` is never high while `busy` is high.
- R7: A faulting operation raises `done` and `fault` together for one cycle, right after the accepting edge. `busy` stays low, and `quotient` and `remainder` keep their previous values.
- R8: A `start` seen while `busy` is high is ignored. The running operation's timing and results are unchanged.
- R9: A synchronous reset (`rst`=1) clears `busy`, `done`, `fault`, `quotient` and `remainder` to zero, including in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Offer an operation; taken only when busy is low |
| signed_mode | input | 1 | 0 = unsigned, 1 = two's-complement signed |
| dividend_hi | input | 8 | Upper half of the dividend |
| dividend_lo | input | 8 | Lower half of the dividend |
| divisor | input | 8 | Divisor |
| busy | output | 1 | Iteration in progress; new offers are refused |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | With done: the quotient would not fit or the divisor is zero |
| quotient | output | 8 | Last successful quotient |
| remainder | output | 8 | Last successful remainder |

## Verification
The assertions assume that `rst` is high at the first clock edge. They also assume that `start`, `signed_mode` and the operand inputs carry known values on every edge, because the fault checks and the operand capture in the checker read them directly. The arithmetic checks depend on the operands being sampled only on the accepting edge, so the checker captures them there and holds them. The bench therefore changes every input only on the falling clock edge and holds reset for several cycles first. It also drives fresh, different operands together with `start` while the block is busy, so any use of refused operands would break the result checks.

// File: rtl/ndiv_pkg.sv
package ndiv_pkg;
  localparam int unsigned NDIV_W_DEFAULT = 8;

  typedef enum logic [0:0] {
    ARITH_UNSIGNED = 1'b0,
    ARITH_SIGNED   = 1'b1
  } arith_e;
endpackage

// File: rtl/ndiv_sign_prep.sv
module ndiv_sign_prep
  import ndiv_pkg::*;
#(
  parameter int unsigned W = NDIV_W_DEFAULT
) (
  input  logic           signed_mode,
  input  logic [W-1:0]   dvd_hi,
  input  logic [W-1:0]   dvd_lo,
  input  logic [W-1:0]   dvs,
  output logic [2*W-1:0] dvd_mag,
  output logic [W-1:0]   dvs_mag,
  output logic           quo_neg,
  output logic           rem_neg
);
  logic           is_signed;
  logic           dvd_sign;
  logic           dvs_sign;
  logic [2*W-1:0] dvd_full;

  assign is_signed = (arith_e'(signed_mode) == ARITH_SIGNED);
  assign dvd_full  = {dvd_hi, dvd_lo};
  assign dvd_sign  = is_signed & dvd_hi[W-1];
  assign dvs_sign  = is_signed & dvs[W-1];

  // Two's-complement negation gives the correct unsigned magnitude even for
  // the most negative value.
  assign dvd_mag = dvd_sign ? (~dvd_full + 1'b1) : dvd_full;
  assign dvs_mag = dvs_sign ? (~dvs + 1'b1) : dvs;
  assign quo_neg = dvd_sign ^ dvs_sign;
  assign rem_neg = dvd_sign;
endmodule

// File: rtl/ndiv_range_guard.sv
module ndiv_range_guard
  import ndiv_pkg::*;
#(
  parameter int unsigned W = NDIV_W_DEFAULT
) (
  input  logic           signed_mode,
  input  logic           quo_neg,
  input  logic [2*W-1:0] dvd_mag,
  input  logic [W-1:0]   dvs_mag,
  output logic           bad
);
  localparam int unsigned BW = 2*W + 1;

  logic [BW-1:0] d_ext;
  logic [BW-1:0] bound;

  assign d_ext = {{(W+1){1'b0}}, dvs_mag};

  // The quotient magnitude is at most L exactly when the dividend magnitude is
  // below (L+1)*divisor. Unsigned: L+1 = 2^W. Signed positive: L+1 = 2^(W-1).
  // Signed negative: L+1 = 2^(W-1)+1. A zero divisor gives a zero bound.
  always_comb begin
    if (arith_e'(signed_mode) == ARITH_UNSIGNED)
      bound = d_ext << W;
    else if (quo_neg)
      bound = (d_ext << (W-1)) + d_ext;
    else
      bound = d_ext << (W-1);
  end

  assign bad = ({1'b0, dvd_mag} >= bound);
endmodule

// File: rtl/ndiv_restore_step.sv
module ndiv_restore_step #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0]   trial;
  logic [W-1:0] diff;
  logic         take;

  // rem_i < dvs_i holds on entry, so trial < 2*dvs_i and the difference
  // fits in W bits.
  assign trial = {rem_i, quo_i[W-1]};
  assign take  = (trial >= {1'b0, dvs_i});
  assign diff  = trial[W-1:0] - dvs_i;
  assign rem_o = take ? diff : trial[W-1:0];
  assign quo_o = {quo_i[W-2:0], take};
endmodule

// File: rtl/narrow_divider.sv
module narrow_divider
  import ndiv_pkg::*;
#(
  parameter int unsigned W = NDIV_W_DEFAULT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         signed_mode,
  input  logic [W-1:0] dividend_hi,
  input  logic [W-1:0] dividend_lo,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         fault,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [2*W-1:0] in_dvd_mag;
  logic [W-1:0]   in_dvs_mag;
  logic           in_quo_neg;
  logic           in_rem_neg;
  logic           in_bad;

  logic [CW-1:0]  steps_left;
  logic [W-1:0]   rem_r;
  logic [W-1:0]   quo_r;
  logic [W-1:0]   dvs_r;
  logic           quo_neg_r;
  logic           rem_neg_r;
  logic [W-1:0]   nxt_rem;
  logic [W-1:0]   nxt_quo;
  logic           accept;

  ndiv_sign_prep #(.W(W)) u_prep (
    .signed_mode (signed_mode),
    .dvd_hi      (dividend_hi),
    .dvd_lo      (dividend_lo),
    .dvs         (divisor),
    .dvd_mag     (in_dvd_mag),
    .dvs_mag     (in_dvs_mag),
    .quo_neg     (in_quo_neg),
    .rem_neg     (in_rem_neg)
  );

  ndiv_range_guard #(.W(W)) u_guard (
    .signed_mode (signed_mode),
    .quo_neg     (in_quo_neg),
    .dvd_mag     (in_dvd_mag),
    .dvs_mag     (in_dvs_mag),
    .bad         (in_bad)
  );

  ndiv_restore_step #(.W(W)) u_step (
    .rem_i (rem_r),
    .quo_i (quo_r),
    .dvs_i (dvs_r),
    .rem_o (nxt_rem),
    .quo_o (nxt_quo)
  );

  assign accept = start & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      fault      <= 1'b0;
      quotient   <= '0;
      remainder  <= '0;
      steps_left <= '0;
      rem_r      <= '0;
      quo_r      <= '0;
      dvs_r      <= '0;
      quo_neg_r  <= 1'b0;
      rem_neg_r  <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      if (busy) begin
        rem_r      <= nxt_rem;
        quo_r      <= nxt_quo;
        steps_left <= steps_left - 1'b1;
        if (steps_left == CW'(1)) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          quotient  <= quo_neg_r ? (~nxt_quo + 1'b1) : nxt_quo;
          remainder <= rem_neg_r ? (~nxt_rem + 1'b1) : nxt_rem;
        end
      end else if (accept) begin
        if (in_bad) begin
          done  <= 1'b1;
          fault <= 1'b1;
        end else begin
          busy       <= 1'b1;
          steps_left <= CW'(W);
          rem_r      <= in_dvd_mag[2*W-1:W];
          quo_r      <= in_dvd_mag[W-1:0];
          dvs_r      <= in_dvs_mag;
          quo_neg_r  <= in_quo_neg;
          rem_neg_r  <= in_rem_neg;
        end
      end
    end
  end
endmodule

// File: rtl/narrow_divider_chk.sv
module narrow_divider_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         signed_mode,
  input logic [W-1:0] dividend_hi,
  input logic [W-1:0] dividend_lo,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic         fault,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder
);
  localparam int unsigned LW = $clog2(W + 2);
  localparam int unsigned XW = 2*W + 2;

  logic           cap_signed;
  logic [2*W-1:0] cap_dvd;
  logic [W-1:0]   cap_dvs;
  logic [LW-1:0]  run_len;
  logic           uns_ok;
  logic           sgn_ok;
  logic [XW-1:0]  u_q, u_d, u_r, u_n;
  logic signed [XW-1:0] s_q, s_d, s_r, s_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_signed <= 1'b0;
      cap_dvd    <= '0;
      cap_dvs    <= '0;
      run_len    <= '0;
    end else if (start && !busy) begin
      cap_signed <= signed_mode;
      cap_dvd    <= {dividend_hi, dividend_lo};
      cap_dvs    <= divisor;
      run_len    <= '0;
    end else if (busy) begin
      run_len    <= run_len + 1'b1;
    end
  end

  always_comb begin
    u_q = {{(W+2){1'b0}}, quotient};
    u_d = {{(W+2){1'b0}}, cap_dvs};
    u_r = {{(W+2){1'b0}}, remainder};
    u_n = {2'b00, cap_dvd};
    s_q = $signed({{(W+2){quotient[W-1]}}, quotient});
    s_d = $signed({{(W+2){cap_dvs[W-1]}}, cap_dvs});
    s_r = $signed({{(W+2){remainder[W-1]}}, remainder});
    s_n = $signed({{2{cap_dvd[2*W-1]}}, cap_dvd});
    uns_ok = (u_q * u_d + u_r == u_n) && (remainder < cap_dvs);
    sgn_ok = (s_q * s_d + s_r == s_n);
  end

  assert_unsigned_identity_R1: assert property (@(posedge clk) disable iff (rst)
    (done && !fault && !cap_signed) |-> uns_ok);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !signed_mode && (dividend_hi >= divisor)) |=> (done && fault));

  assert_zero_divisor_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (divisor == '0)) |=> (done && fault));

  assert_signed_identity_R4: assert property (@(posedge clk) disable iff (rst)
    (done && !fault && cap_signed) |-> sgn_ok);

  assert_min_by_minus_one_R5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && signed_mode && ({dividend_hi, dividend_lo} == {1'b1, {(2*W-1){1'b0}}})
     && (divisor == '1)) |=> (done && fault));

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !fault) |-> (run_len == LW'(W)));

  assert_no_done_while_busy_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  assert_fault_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    fault |-> (done && !busy));

  assert_fault_keeps_results_R7: assert property (@(posedge clk) disable iff (rst)
    fault |-> ($stable(quotient) && $stable(remainder)));

  assert_busy_refuses_start_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> !fault);

  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (!busy && !done && !fault && (quotient == '0) && (remainder == '0)));
endmodule

bind narrow_divider narrow_divider_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .signed_mode (signed_mode),
  .dividend_hi (dividend_hi),
  .dividend_lo (dividend_lo),
  .divisor     (divisor),
  .busy        (busy),
  .done        (done),
  .fault       (fault),
  .quotient    (quotient),
  .remainder   (remainder)
);

// File: tb/tb_narrow_divider.sv
module tb_narrow_divider;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic signed_mode = 1'b0;
  logic [W-1:0] dividend_hi = '0;
  logic [W-1:0] dividend_lo = '0;
  logic [W-1:0] divisor = '0;
  logic busy, done, fault;
  logic [W-1:0] quotient, remainder;

  narrow_divider #(.W(W)) dut (
    .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
    .dividend_hi(dividend_hi), .dividend_lo(dividend_lo), .divisor(divisor),
    .busy(busy), .done(done), .fault(fault),
    .quotient(quotient), .remainder(remainder)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;
  string tag = "R9";

  // Behavioural reference model, advanced on every rising edge.
  bit m_busy = 0, m_done = 0, m_fault = 0;
  int m_cnt = 0;
  logic [W-1:0] m_q = '0, m_r = '0, p_q = '0, p_r = '0;

  always @(posedge clk) begin
    int dd, vv, qq, rr;
    bit bad;
    if (rst) begin
      m_busy = 0; m_done = 0; m_fault = 0; m_q = '0; m_r = '0; m_cnt = 0;
    end else begin
      m_done = 0; m_fault = 0;
      if (m_busy) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_q = p_q; m_r = p_r;
        end
      end else if (start) begin
        if (signed_mode) begin
          dd = int'($signed({dividend_hi, dividend_lo}));
          vv = int'($signed(divisor));
        end else begin
          dd = int'({dividend_hi, dividend_lo});
          vv = int'(divisor);
        end
        bad = (vv == 0);
        if (!bad) begin
          qq = dd / vv;
          rr = dd % vv;
          if (signed_mode) bad = (qq > 127) || (qq < -128);
          else bad = (qq > 255);
        end
        if (bad) begin
          m_done = 1; m_fault = 1;
        end else begin
          m_busy = 1; m_cnt = W; p_q = qq[W-1:0]; p_r = rr[W-1:0];
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Compare every output against the model away from the active edge.
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (busy !== m_busy || done !== m_done || fault !== m_fault ||
          quotient !== m_q || remainder !== m_r) begin
        fails++;
        $display("FAIL %s t=%0t actual busy=%0b done=%0b fault=%0b q=%02h r=%02h expected busy=%0b done=%0b fault=%0b q=%02h r=%02h",
                 tag, $time, busy, done, fault, quotient, remainder,
                 m_busy, m_done, m_fault, m_q, m_r);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL R6 watchdog expired actual cycles=%0d expected fewer than %0d", cycles, 150000);
      summary();
      $finish;
    end
  end

  function automatic string classify(bit s, logic [15:0] dvd, logic [7:0] d);
    int dd, vv, qq;
    if (d == 0) return "R3/R7";
    if (s) begin
      dd = int'($signed(dvd));
      vv = int'($signed(d));
      qq = dd / vv;
      if (qq > 127 || qq < -128) return "R5/R7";
      return "R4/R6";
    end
    if (dvd[15:8] >= d) return "R2/R7";
    return "R1/R6";
  endfunction

  // Offer one operation; optionally keep offering other operands while busy.
  task automatic run_op(bit s, logic [15:0] dvd, logic [7:0] d, int extra);
    @(negedge clk);
    tag = classify(s, dvd, d);
    if (extra > 0) tag = {tag, " R8"};
    signed_mode = s; dividend_hi = dvd[15:8]; dividend_lo = dvd[7:0]; divisor = d;
    start = 1'b1;
    for (int i = 0; i < extra; i++) begin
      @(negedge clk);
      signed_mode = ~s; dividend_hi = 8'h00; dividend_lo = 8'h07; divisor = 8'h02;
    end
    @(negedge clk);
    start = 1'b0;
    repeat (W + 3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: unsigned results
    run_op(0, 16'h00FF, 8'h10, 0);
    run_op(0, 16'h0FFF, 8'h10, 0);
    run_op(0, 16'hFEFF, 8'hFF, 0);
    // R2: high half not below divisor; results must stay from the last op
    run_op(0, 16'h1000, 8'h10, 0);
    run_op(0, 16'h2A00, 8'h2A, 0);
    // R3: zero divisor, both modes
    run_op(0, 16'h0012, 8'h00, 0);
    run_op(1, 16'hFF00, 8'h00, 0);
    // R4: signed results and signs
    run_op(1, 16'hFF9C, 8'h07, 0);
    run_op(1, 16'h0064, 8'hF9, 0);
    run_op(1, 16'hFFFD, 8'h05, 0);
    run_op(1, 16'hC000, 8'h80, 0);
    run_op(1, 16'h3F80, 8'h80, 0);
    // R5: signed range limits
    run_op(1, 16'h8000, 8'hFF, 0);
    run_op(1, 16'h8000, 8'h80, 0);
    run_op(1, 16'h4000, 8'h80, 0);
    run_op(1, 16'h0080, 8'h01, 0);
    run_op(1, 16'hFF80, 8'h01, 0);
    // R8: offers during busy are dropped
    run_op(0, 16'h3456, 8'h9A, 3);
    run_op(1, 16'hF123, 8'h35, 5);
    // R7: fault then an immediate new offer while done is high
    @(negedge clk);
    tag = "R7";
    signed_mode = 0; dividend_hi = 8'h40; dividend_lo = 8'h00; divisor = 8'h20; start = 1'b1;
    @(negedge clk);
    dividend_hi = 8'h01; dividend_lo = 8'h23; divisor = 8'h20;
    @(negedge clk);
    start = 1'b0;
    repeat (W + 3) @(negedge clk);
    // R9: reset in the middle of an operation
    @(negedge clk);
    tag = "R9";
    signed_mode = 0; dividend_hi = 8'h05; dividend_lo = 8'h55; divisor = 8'h33; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // Mixed operands in both modes
    for (int k = 0; k < 80; k++) begin
      logic [7:0] d;
      logic [15:0] dvd;
      int qv, dv;
      d = 8'($urandom_range(0, 255));
      case (k % 4)
        0: dvd = {8'($urandom_range(0, 255)) % ((d == 0) ? 8'd1 : d), 8'($urandom_range(0, 255))};
        1: dvd = 16'($urandom_range(0, 65535));
        2: begin
          qv = int'($urandom_range(0, 255)) - 128;
          dv = int'($signed(d));
          dvd = 16'(qv * dv);
        end
        default: dvd = 16'(int'($urandom_range(0, 4000)) - 2000);
      endcase
      run_op(k[1], dvd, d, 0);
    end
    finished = 1;
    summary();
    $finish;
  end
endmodule